// File: doc/BRIEF.md
# Accumulator Processor Core

A multi-cycle 16-bit processor core that reads program words and data words from one unified, synchronous memory. Its state is a program counter, a memory address register, an accumulator, a zero flag, a carry/borrow flag and a bank of sixteen register slots. Every ALU operation takes the accumulator as its first operand and writes its result back to the accumulator. The second operand comes from a register slot. When the instruction names slot 0, the second operand is instead a word read from the zero page, at the address given by the instruction's low byte.

A word becomes visible on `mem_rdata_i` one clock after its address is driven. The core puts the program counter on the address bus only during the fetch cycle. In every later cycle of an instruction, the memory address register drives the bus. There is no jump, so a program runs straight forward from address 0 after reset. The bench places code low in memory and zero-page data in the upper half of the first 256 words.

Top module: `acc16_core`

## Requirements
- R1: While reset is held, and for the first fetch cycle after reset is released, the core drives address 0 with the write enable low. The accumulator, the zero flag and the carry flag read as 0 after reset. Register slots keep their contents across reset.
- R2: An instruction word carries the operation in bits 15:12, the slot number in bits 11:8 and a zero-page byte in bits 7:0. A zero-page address is that byte extended with zeros to the address width. When the slot number is nonzero, the zero-page byte is ignored.
- R3: In the first cycle of every instruction, the address bus holds the program counter. An instruction takes 3 cycles when it uses only registers, when it has no effect, or when it is a zero-page store. It takes 4 cycles when it reads a memory operand or a constant. The program counter advances by 1, or by 2 for a constant load.
- R4: Operations 8 (AND), 9 (OR) and F (XOR) combine the accumulator with the operand and write the result to the accumulator. They set the zero flag when the result is 0 and clear the carry flag.
- R5: Operation A adds the operand to the accumulator, and the carry flag takes the carry out of bit 15. Operation B subtracts the operand from the accumulator, and the carry flag is 1 when the operand is greater than the accumulator, treated as unsigned numbers. Both operations set the zero flag when the result is 0.
- R6: Operation C sets both flags exactly as operation B would, and leaves the accumulator unchanged.
- R7: For operations 8, 9, A, B, C and F, slot number 0 selects the memory word at the zero-page address as the operand, in place of a register slot.
- R8: Operation 1 loads the word that follows the instruction into slot n. When n is 0, the word goes to the accumulator. The flags do not change.
- R9: Operation 2 with a nonzero slot copies that slot into the accumulator. With slot 0, it loads the accumulator from the zero-page address. The flags do not change.
- R10: Operation 3 with a nonzero slot copies the accumulator into that slot. With slot 0, it writes the accumulator to the zero-page address, with the write enable high for exactly the third cycle of the instruction. No other instruction raises the write enable.
- R11: Operations 0, 4, 5, 6, 7, D and E change neither the accumulator, the flags, the register slots nor memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. Asserts asynchronously and is released through a synchronizer. |
| mem_addr_o | output | ADDR_W (16) | Memory address: the program counter in the fetch cycle, the address register in every other cycle |
| mem_wdata_o | output | DATA_W (16) | Write data, always the accumulator |
| mem_we_o | output | 1 | Write enable for a zero-page store |
| mem_rdata_i | input | DATA_W (16) | Read data for the address driven one cycle earlier |
| zero_flag_o | output | 1 | Zero flag |
| carry_flag_o | output | 1 | Carry after an add, borrow after a subtract or compare |

## Verification
The bench targets these edge cases:
- An add that wraps to zero. If the carry were dropped, or the zero flag were taken before the wrap, the flags after the add would not match.
- A compare of equal values. If a compare wrote its difference back, the next zero-page store would put a wrong word in memory.
- Slot 0 used with an ALU operation. If slot 0 were treated as an ordinary register, the core would read a stale slot, and it would also finish one cycle early, so the next fetch address would land in the wrong cycle.
- Random programs that mix unlisted operations, constant loads and nonzero payload bytes on register forms. A core that skips the constant word wrongly, or that acts on an unlisted operation, makes the fetch address, the write strobe or the final zero-page contents differ from the bench's instruction-level model.

// File: rtl/acc16_pkg.sv
package acc16_pkg;

  localparam int OPC_W   = 4;
  localparam int RSEL_W  = 4;
  localparam int ZP_W    = 8;
  localparam int INSTR_W = OPC_W + RSEL_W + ZP_W;
  localparam int HI_W    = OPC_W + RSEL_W;

  localparam logic [OPC_W-1:0] OPC_SET = 4'h1;
  localparam logic [OPC_W-1:0] OPC_LD  = 4'h2;
  localparam logic [OPC_W-1:0] OPC_ST  = 4'h3;
  localparam logic [OPC_W-1:0] OPC_AND = 4'h8;
  localparam logic [OPC_W-1:0] OPC_OR  = 4'h9;
  localparam logic [OPC_W-1:0] OPC_ADD = 4'hA;
  localparam logic [OPC_W-1:0] OPC_SUB = 4'hB;
  localparam logic [OPC_W-1:0] OPC_CMP = 4'hC;
  localparam logic [OPC_W-1:0] OPC_XOR = 4'hF;

  typedef enum logic [2:0] {
    PH_FETCH,
    PH_LATCH,
    PH_EXEC,
    PH_MADDR,
    PH_MDATA
  } phase_e;

  typedef enum logic [2:0] {
    FN_AND,
    FN_OR,
    FN_XOR,
    FN_ADD,
    FN_SUB
  } alu_fn_e;

  typedef enum logic [1:0] {
    AC_KEEP,
    AC_ALU,
    AC_RF,
    AC_MEM
  } acc_src_e;

  function automatic logic op_is_alu(input logic [OPC_W-1:0] op);
    return (op == OPC_AND) || (op == OPC_OR) || (op == OPC_ADD) ||
           (op == OPC_SUB) || (op == OPC_CMP) || (op == OPC_XOR);
  endfunction

  function automatic logic op_uses_slot(input logic [OPC_W-1:0] op);
    return op_is_alu(op) || (op == OPC_LD) || (op == OPC_ST);
  endfunction

  function automatic alu_fn_e op_alu_fn(input logic [OPC_W-1:0] op);
    alu_fn_e fn;
    case (op)
      OPC_AND: fn = FN_AND;
      OPC_OR:  fn = FN_OR;
      OPC_XOR: fn = FN_XOR;
      OPC_ADD: fn = FN_ADD;
      default: fn = FN_SUB;
    endcase
    return fn;
  endfunction

endpackage

// File: rtl/acc16_rst_sync.sv
module acc16_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = 1'b1;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/acc16_alu.sv
module acc16_alu
  import acc16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_fn_e      fn_i,
  output logic [W-1:0] y_o,
  output logic         cy_o,
  output logic         zero_o
);

  logic [W:0] sum_w;
  logic [W:0] dif_w;

  assign sum_w = {1'b0, a_i} + {1'b0, b_i};
  assign dif_w = {1'b0, a_i} - {1'b0, b_i};

  always_comb begin
    y_o  = '0;
    cy_o = 1'b0;
    case (fn_i)
      FN_AND: y_o = a_i & b_i;
      FN_OR:  y_o = a_i | b_i;
      FN_XOR: y_o = a_i ^ b_i;
      FN_ADD: {cy_o, y_o} = sum_w;
      FN_SUB: {cy_o, y_o} = dif_w;
      default: y_o = '0;
    endcase
  end

  assign zero_o = (y_o == '0);

  always_comb begin
    if (fn_i == FN_SUB) begin
      assert_borrow_is_less_R5: assert (cy_o == (a_i < b_i));
    end
  end

endmodule

// File: rtl/acc16_regfile.sv
module acc16_regfile #(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [IW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [IW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);

  logic [W-1:0] slot_q [DEPTH];

  // Slot 0 is never stored: that index means "zero page" or "accumulator".
  always_ff @(posedge clk) begin
    for (int i = 1; i < DEPTH; i++) begin
      if (we_i && (waddr_i == IW'(i))) slot_q[i] <= wdata_i;
    end
  end

  assign rdata_o = (raddr_i == '0) ? '0 : slot_q[raddr_i];

  assert_slot0_unwritten_R8: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |-> (waddr_i != '0));

endmodule

// File: rtl/acc16_ctrl.sv
module acc16_ctrl
  import acc16_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HI_W-1:0]   fetch_hi_i,
  output phase_e            phase_o,
  output logic [OPC_W-1:0]  op_o,
  output logic [RSEL_W-1:0] rsel_o,
  output logic              pc_step_o,
  output logic              mar_ld_o,
  output logic              mar_const_o,
  output logic              mem_we_o,
  output logic              flag_we_o,
  output logic              rf_we_o,
  output logic              rf_from_mem_o,
  output logic              opnd_mem_o,
  output acc_src_e          acc_src_o,
  output alu_fn_e           alu_fn_o
);

  phase_e          phase_q, phase_d;
  logic [HI_W-1:0] ir_q, ir_d;

  logic [OPC_W-1:0]  new_op;
  logic [RSEL_W-1:0] new_rs;
  logic              new_needs_mem;
  logic              cur_rz;

  assign new_op        = fetch_hi_i[HI_W-1 -: OPC_W];
  assign new_rs        = fetch_hi_i[RSEL_W-1:0];
  assign new_needs_mem = (new_op == OPC_SET) || (op_uses_slot(new_op) && (new_rs == '0));

  assign op_o   = ir_q[HI_W-1 -: OPC_W];
  assign rsel_o = ir_q[RSEL_W-1:0];
  assign cur_rz = (rsel_o == '0);

  // next-state process
  always_comb begin
    phase_d = phase_q;
    ir_d    = ir_q;
    case (phase_q)
      PH_FETCH: phase_d = PH_LATCH;
      PH_LATCH: begin
        ir_d    = fetch_hi_i;
        phase_d = new_needs_mem ? PH_MADDR : PH_EXEC;
      end
      PH_EXEC:  phase_d = PH_FETCH;
      PH_MADDR: phase_d = (op_o == OPC_ST) ? PH_FETCH : PH_MDATA;
      PH_MDATA: phase_d = PH_FETCH;
      default:  phase_d = PH_FETCH;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_FETCH;
      ir_q    <= '0;
    end else begin
      phase_q <= phase_d;
      ir_q    <= ir_d;
    end
  end

  // control decode
  always_comb begin
    pc_step_o     = 1'b0;
    mar_ld_o      = 1'b0;
    mar_const_o   = 1'b0;
    mem_we_o      = 1'b0;
    flag_we_o     = 1'b0;
    rf_we_o       = 1'b0;
    rf_from_mem_o = 1'b0;
    opnd_mem_o    = 1'b0;
    acc_src_o     = AC_KEEP;
    alu_fn_o      = op_alu_fn(op_o);
    case (phase_q)
      PH_LATCH: begin
        pc_step_o   = 1'b1;
        mar_ld_o    = 1'b1;
        mar_const_o = (new_op == OPC_SET);
      end
      PH_EXEC: begin
        if (op_is_alu(op_o)) begin
          flag_we_o = 1'b1;
          acc_src_o = (op_o == OPC_CMP) ? AC_KEEP : AC_ALU;
        end else if (op_o == OPC_LD) begin
          acc_src_o = AC_RF;
        end else if (op_o == OPC_ST) begin
          rf_we_o = 1'b1;
        end
      end
      PH_MADDR: mem_we_o = (op_o == OPC_ST);
      PH_MDATA: begin
        opnd_mem_o = 1'b1;
        if (op_is_alu(op_o)) begin
          flag_we_o = 1'b1;
          acc_src_o = (op_o == OPC_CMP) ? AC_KEEP : AC_ALU;
        end else if (op_o == OPC_LD) begin
          acc_src_o = AC_MEM;
        end else if (op_o == OPC_SET) begin
          pc_step_o = 1'b1;
          if (cur_rz) begin
            acc_src_o = AC_MEM;
          end else begin
            rf_we_o       = 1'b1;
            rf_from_mem_o = 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  assign phase_o = phase_q;

  assert_fetch_then_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q == PH_FETCH |=> phase_q == PH_LATCH);

  assert_last_phase_refetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_EXEC || phase_q == PH_MDATA) |=> phase_q == PH_FETCH);

  assert_store_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |=> !mem_we_o);

endmodule

// File: rtl/acc16_core.sv
module acc16_core
  import acc16_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              zero_flag_o,
  output logic              carry_flag_o
);

  localparam int SLOTS  = 1 << RSEL_W;
  localparam int ZP_PAD = ADDR_W - ZP_W;

  logic rst_ni;

  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [ADDR_W-1:0] mar_q, mar_d;
  logic [DATA_W-1:0] acc_q, acc_d;
  logic              zf_q, zf_d;
  logic              cf_q, cf_d;

  phase_e            phase;
  logic [OPC_W-1:0]  op;
  logic [RSEL_W-1:0] rsel;
  logic              pc_step, mar_ld, mar_const, flag_we;
  logic              rf_we, rf_from_mem, opnd_mem;
  acc_src_e          acc_src;
  alu_fn_e           alu_fn;

  logic [DATA_W-1:0] rf_rdata, rf_wdata, operand, alu_y;
  logic              alu_cy, alu_zero;
  logic [ADDR_W-1:0] pc_inc;

  acc16_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_n_sync_o (rst_ni)
  );

  acc16_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_ni),
    .fetch_hi_i    (mem_rdata_i[DATA_W-1 -: HI_W]),
    .phase_o       (phase),
    .op_o          (op),
    .rsel_o        (rsel),
    .pc_step_o     (pc_step),
    .mar_ld_o      (mar_ld),
    .mar_const_o   (mar_const),
    .mem_we_o      (mem_we_o),
    .flag_we_o     (flag_we),
    .rf_we_o       (rf_we),
    .rf_from_mem_o (rf_from_mem),
    .opnd_mem_o    (opnd_mem),
    .acc_src_o     (acc_src),
    .alu_fn_o      (alu_fn)
  );

  acc16_regfile #(.W(DATA_W), .DEPTH(SLOTS)) u_rf (
    .clk     (clk),
    .rst_n   (rst_ni),
    .we_i    (rf_we),
    .waddr_i (rsel),
    .wdata_i (rf_wdata),
    .raddr_i (rsel),
    .rdata_o (rf_rdata)
  );

  acc16_alu #(.W(DATA_W)) u_alu (
    .a_i    (acc_q),
    .b_i    (operand),
    .fn_i   (alu_fn),
    .y_o    (alu_y),
    .cy_o   (alu_cy),
    .zero_o (alu_zero)
  );

  assign operand  = opnd_mem ? mem_rdata_i : rf_rdata;
  assign rf_wdata = rf_from_mem ? mem_rdata_i : acc_q;
  assign pc_inc   = pc_q + ADDR_W'(1);

  // next-state process
  always_comb begin
    pc_d  = pc_step ? pc_inc : pc_q;
    mar_d = mar_q;
    if (mar_ld) begin
      mar_d = mar_const ? pc_inc : {{ZP_PAD{1'b0}}, mem_rdata_i[ZP_W-1:0]};
    end
    case (acc_src)
      AC_ALU:  acc_d = alu_y;
      AC_RF:   acc_d = rf_rdata;
      AC_MEM:  acc_d = mem_rdata_i;
      default: acc_d = acc_q;
    endcase
    zf_d = flag_we ? alu_zero : zf_q;
    cf_d = flag_we ? alu_cy   : cf_q;
  end

  // register process
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      mar_q <= '0;
      acc_q <= '0;
      zf_q  <= 1'b0;
      cf_q  <= 1'b0;
    end else begin
      pc_q  <= pc_d;
      mar_q <= mar_d;
      acc_q <= acc_d;
      zf_q  <= zf_d;
      cf_q  <= cf_d;
    end
  end

  assign mem_addr_o   = (phase == PH_FETCH) ? pc_q : mar_q;
  assign mem_wdata_o  = acc_q;
  assign zero_flag_o  = zf_q;
  assign carry_flag_o = cf_q;

  assert_pc_advance_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    phase == PH_LATCH |=> pc_q == $past(pc_q) + ADDR_W'(1));

  assert_cmp_keeps_acc_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    ((phase == PH_EXEC || phase == PH_MDATA) && op == OPC_CMP) |=> $stable(acc_q));

  assert_flags_only_on_alu_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (phase == PH_FETCH || phase == PH_LATCH || phase == PH_MADDR) |=> ($stable(zf_q) && $stable(cf_q)));

  assert_store_in_zero_page_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_we_o |-> (mem_addr_o[ADDR_W-1:ZP_W] == '0 && phase == PH_MADDR));

  assert_idle_op_quiet_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    (phase == PH_EXEC && !op_uses_slot(op)) |=> ($stable(acc_q) && $stable(zf_q) && $stable(cf_q)));

endmodule

// File: tb/acc16_core_bench.sv
`timescale 1ns/1ps
module acc16_core_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_we, zf, cf;

  int n_chk = 0;
  int n_fail = 0;

  logic [15:0] bmem  [1024];
  logic [15:0] m_mem [1024];
  logic [15:0] m_rf  [16];
  logic [15:0] m_pc, m_acc;
  logic        m_z, m_c;
  int          wp;

  always #4 clk = ~clk;

  acc16_core u_acc16_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_addr_o   (mem_addr),
    .mem_wdata_o  (mem_wdata),
    .mem_we_o     (mem_we),
    .mem_rdata_i  (mem_rdata),
    .zero_flag_o  (zf),
    .carry_flag_o (cf)
  );

  always @(posedge clk) begin
    if (mem_we) bmem[mem_addr[9:0]] <= mem_wdata;
    mem_rdata <= bmem[mem_addr[9:0]];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic put(input logic [15:0] w);
    bmem[wp]  = w;
    m_mem[wp] = w;
    wp++;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) begin
      bmem[i]  = 16'h0000;
      m_mem[i] = 16'h0000;
    end
    for (int i = 'h80; i < 'h100; i++) begin
      logic [15:0] v;
      v = 16'($urandom);
      bmem[i]  = v;
      m_mem[i] = v;
    end
    wp = 0;
  endtask

  function automatic bit is_alu(input logic [3:0] op);
    return op inside {4'h8, 4'h9, 4'hA, 4'hB, 4'hC, 4'hF};
  endfunction

  function automatic bit uses_slot(input logic [3:0] op);
    return is_alu(op) || op == 4'h2 || op == 4'h3;
  endfunction

  function automatic int instr_len(input logic [3:0] op, input logic [3:0] r);
    if (op == 4'h1) return 4;
    if ((is_alu(op) || op == 4'h2) && r == 4'h0) return 4;
    return 3;
  endfunction

  function automatic string req_of(input logic [3:0] op, input logic [3:0] r);
    if (is_alu(op) && r == 4'h0) return "R7";
    case (op)
      4'h8, 4'h9, 4'hF: return "R4";
      4'hA, 4'hB:       return "R5";
      4'hC:             return "R6";
      4'h1:             return "R8";
      4'h2:             return "R9";
      4'h3:             return "R10";
      default:          return "R11";
    endcase
  endfunction

  // instruction-level reference model
  task automatic model_step();
    logic [15:0] w, opnd, k;
    logic [3:0]  op, r;
    logic [16:0] res;
    w    = m_mem[m_pc[9:0]];
    op   = w[15:12];
    r    = w[11:8];
    opnd = (r == 4'h0) ? m_mem[{2'b00, w[7:0]}] : m_rf[r];
    case (op)
      4'h1: begin
        k = m_mem[m_pc[9:0] + 10'd1];
        if (r == 4'h0) m_acc = k; else m_rf[r] = k;
        m_pc = m_pc + 16'd2;
      end
      4'h2: m_acc = opnd;
      4'h3: if (r == 4'h0) m_mem[{2'b00, w[7:0]}] = m_acc; else m_rf[r] = m_acc;
      4'h8: begin m_acc = m_acc & opnd; m_z = (m_acc == 0); m_c = 1'b0; end
      4'h9: begin m_acc = m_acc | opnd; m_z = (m_acc == 0); m_c = 1'b0; end
      4'hF: begin m_acc = m_acc ^ opnd; m_z = (m_acc == 0); m_c = 1'b0; end
      4'hA: begin res = {1'b0, m_acc} + {1'b0, opnd}; m_acc = res[15:0]; m_z = (res[15:0] == 0); m_c = res[16]; end
      4'hB: begin m_c = (opnd > m_acc); m_acc = m_acc - opnd; m_z = (m_acc == 0); end
      4'hC: begin m_c = (opnd > m_acc); m_z = (m_acc == opnd); end
      default: ;
    endcase
    if (op != 4'h1) m_pc = m_pc + 16'd1;
  endtask

  task automatic run_prog();
    int mism;
    m_pc = 16'h0; m_acc = 16'h0; m_z = 1'b0; m_c = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(mem_addr == 16'h0 && !mem_we, "R1", "first fetch address/strobe", {15'h0, mem_we, mem_addr}, 32'h0);
    chk({zf, cf} == 2'b00, "R1", "flags after reset", {30'h0, zf, cf}, 32'h0);
    while (m_pc < 16'(wp)) begin
      logic [15:0] w, exp_d;
      logic [3:0]  op, r;
      int          len;
      bit          st, ok_w;
      w     = m_mem[m_pc[9:0]];
      op    = w[15:12];
      r     = w[11:8];
      len   = instr_len(op, r);
      st    = (op == 4'h3) && (r == 4'h0);
      exp_d = m_acc;
      ok_w  = 1'b1;
      for (int off = 0; off < len; off++) begin
        if (mem_we !== (st && off == 2)) ok_w = 1'b0;
        if (st && off == 2) begin
          chk(mem_addr == {8'h00, w[7:0]}, "R2", "store address", {16'h0, mem_addr}, {24'h0, w[7:0]});
          chk(mem_wdata == exp_d, "R10", "store data", {16'h0, mem_wdata}, {16'h0, exp_d});
        end
        @(negedge clk);
      end
      chk(ok_w, "R10", "write strobe timing", {16'h0, w}, {16'h0, w});
      model_step();
      chk(mem_addr == m_pc, "R3", "next fetch address", {16'h0, mem_addr}, {16'h0, m_pc});
      chk({zf, cf} == {m_z, m_c}, req_of(op, r), "flags", {30'h0, zf, cf}, {30'h0, m_z, m_c});
    end
    mism = 0;
    for (int i = 'h80; i < 'h100; i++) if (bmem[i] !== m_mem[i]) mism++;
    chk(mism == 0, "R10", "zero-page contents", 32'(mism), 32'h0);
    rst_n = 1'b0;
  endtask

  task automatic gen_random(input int n);
    logic [3:0] extra [4];
    extra[0] = 4'h8; extra[1] = 4'hA; extra[2] = 4'hB; extra[3] = 4'h3;
    for (int s = 1; s < 16; s++) begin
      put({4'h1, 4'(s), 8'($urandom)});
      put(16'($urandom));
    end
    for (int i = 0; i < n; i++) begin
      int         pick;
      logic [3:0] op, r;
      logic [7:0] pay;
      pick = $urandom_range(0, 19);
      op   = (pick < 16) ? 4'(pick) : extra[pick - 16];
      r    = ($urandom_range(0, 2) == 0) ? 4'h0 : 4'($urandom_range(1, 15));
      pay  = (uses_slot(op) && r == 4'h0) ? (8'h80 | 8'($urandom_range(0, 127))) : 8'($urandom);
      put({op, r, pay});
      if (op == 4'h1) put(16'($urandom));
    end
  endtask

  initial begin
    void'($urandom(32'h0000_51E6));
    // directed program: wrap, borrow, equal compare, unlisted ops, payload ignored
    clear_mem();
    put(16'h1100); put(16'h0001);   // R8: R1 = 1
    put(16'h1000); put(16'hFFFF);   // R8: acc = FFFF
    put(16'hA100);                  // R5: add wraps to 0, carry 1
    put(16'h3080);                  // R10: store 0
    put(16'hB1AA);                  // R5/R2: sub with ignored payload, borrow
    put(16'hC1FF);                  // R6: compare, acc kept
    put(16'h1200); put(16'hFFFF);   // R8: R2 = FFFF
    put(16'hC200);                  // R6: equal compare -> Z1 C0
    put(16'h3081);                  // R10: acc still FFFF
    put(16'hF200);                  // R4: xor to 0
    put(16'h2082);                  // R9: load zero page
    put(16'h9083);                  // R7: or with zero-page word
    put(16'h8200);                  // R4: and
    put(16'h3084);
    put(16'h4123); put(16'hD000); put(16'hE0FF); put(16'h7777); put(16'h5555); put(16'h6000); put(16'h0042); // R11
    put(16'h3300);                  // R10: R3 = acc
    put(16'h2100);                  // R9: acc = R1
    put(16'h2300);                  // R9: acc = R3
    put(16'h3085);
    put(16'hA086);                  // R7: add zero-page word
    put(16'hB087);                  // R7: sub zero-page word
    put(16'h3088);
    put(16'hC088);                  // R6/R7: compare equal with stored word
    put(16'hB200);                  // R5: subtract FFFF
    put(16'h3089);
    run_prog();
    for (int p = 0; p < 6; p++) begin
      @(negedge clk);
      clear_mem();
      gen_random(24);
      run_prog();
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule